// File: doc/BRIEF.md
# SPI Controller Status Flag Register

This block holds the status word of a queued SPI controller. The shift engine and the FIFOs send it event pulses and level signals. The event pulses are end of frame, end of queue and slave transfer start. The levels are FIFO full and empty, and start and stop requests. From these the block keeps sticky event flags, a running/stopped state bit, a transmit fill request flag and a receive drain flag. It also keeps a registered copy of the live FIFO counters and pointers. All of it is packed into one 32-bit word that software reads.

Software clears a sticky flag by writing 1 to its position. A DMA acknowledge can withdraw the transmit fill request once the transmit FIFO is full. Every input is registered, so an event shows in the status word one clock after the edge that samples it.

Bit numbers below are big-endian: bit 0 is the MSB (vector index 31), and bit n is vector index 31-n.

Top module: `spi_stat_reg`

## Requirements
- R1: After reset the status word reads 0x0200_0000: the fill flag (bit 6) is 1 and every other bit is 0.
- R2: The transfer-complete flag at bit 0 (index 31) sets one clock after a `frame_done_i` pulse. It then stays set until it is cleared.
- R3: An `eoq_done_i` pulse sets the end-of-queue flag at bit 3 (index 28). In the same update it clears the running bit at bit 1 (index 30).
- R4: The underflow flag at bit 4 (index 27) sets only when `slv_start_i` arrives while `slave_mode_i` and `tx_empty_i` are both 1. Once set it is sticky.
- R5: The fill flag at bit 6 (index 25) is forced to 1 while `tx_full_i` is 0. While the FIFO is full, a write-1 or `dma_ack_i` clears it. Both are ignored while the FIFO is not full.
- R6: The receive overflow flag at bit 12 (index 19) sets when `frame_done_i` arrives while `rx_full_i` is 1. It is sticky.
- R7: The receive drain flag at bit 14 (index 17) shows, one clock late, that the receive FIFO is not empty. Writes do not change it.
- R8: Writing 1 to a sticky flag position (indices 31, 28, 27, 19) clears that flag. Writing 0 leaves it unchanged.
- R9: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: A `start_req_i` sets the running bit unless `stop_req_i` or `eoq_done_i` arrives in the same cycle. Either of those clears the bit.
- R11: The four 4-bit fields sit at indices 15:12, 11:8, 7:4 and 3:0. These hold the TX counter, TX next pointer, RX counter and RX pop pointer, each registered one clock from its input. Writes do not change these fields or the running bit.
- R12: The reserved positions always read 0 (mask 0x25F5_0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done_i | input | 1 | Pulse: last bit of a frame shifted out |
| eoq_done_i | input | 1 | Pulse: end of a transfer marked last in queue |
| slv_start_i | input | 1 | Pulse: external master started a transfer |
| slave_mode_i | input | 1 | Controller operates as SPI slave |
| tx_full_i | input | 1 | Transmit FIFO full |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_empty_i | input | 1 | Receive FIFO empty |
| start_req_i | input | 1 | Request to enter the running state |
| stop_req_i | input | 1 | Request to enter the stopped state |
| dma_ack_i | input | 1 | DMA acknowledge for the fill request |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write data (1 clears) |
| tx_cnt_i | input | 4 | Transmit FIFO entry count |
| tx_nxt_i | input | 4 | Transmit FIFO next pointer |
| rx_cnt_i | input | 4 | Receive FIFO entry count |
| rx_pop_i | input | 4 | Receive FIFO pop pointer |
| status_o | output | 32 | Packed status word |

## Verification
A hardware set event and a software write-1 clear can land on the same sticky flag in the same cycle. The bench provokes this by pulsing `frame_done_i` or `eoq_done_i` in the same cycle as a write that clears that flag, and it expects the flag to read 1 afterwards. A start request can also meet a stop request in the same cycle. The bench drives both at once and expects the running bit to read 0.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
    localparam int SW_W   = 32;
    localparam int FLD_W  = 4;
    localparam int N_STK  = 4;

    // vector indices of the status word (index = 31 - big-endian bit number)
    localparam int POS_TCF  = 31;
    localparam int POS_RUN  = 30;
    localparam int POS_EOQ  = 28;
    localparam int POS_UFL  = 27;
    localparam int POS_FILL = 25;
    localparam int POS_ROVF = 19;
    localparam int POS_RDRN = 17;
    localparam int TXC_LSB  = 3 * FLD_W;
    localparam int TXP_LSB  = 2 * FLD_W;
    localparam int RXC_LSB  = 1 * FLD_W;
    localparam int RXP_LSB  = 0;

    // slot numbers of the sticky flags
    localparam int STK_TCF  = 0;
    localparam int STK_EOQ  = 1;
    localparam int STK_UFL  = 2;
    localparam int STK_ROVF = 3;

    function automatic int stk_pos(input int slot);
        case (slot)
            STK_TCF:  return POS_TCF;
            STK_EOQ:  return POS_EOQ;
            STK_UFL:  return POS_UFL;
            default:  return POS_ROVF;
        endcase
    endfunction

    typedef struct packed {
        logic             drain;
        logic [FLD_W-1:0] tx_cnt;
        logic [FLD_W-1:0] tx_nxt;
        logic [FLD_W-1:0] rx_cnt;
        logic [FLD_W-1:0] rx_pop;
    } live_t;
endpackage

// File: rtl/spi_stat_w1c.sv
module spi_stat_w1c #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // set beats clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= RST_VAL;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/spi_stat_run.sv
module spi_stat_run (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic eoq_i,
    output logic run_o
);
    logic run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (start_i)         run_d = 1'b1;
        if (stop_i || eoq_i) run_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

    assign run_o = run_q;
endmodule

// File: rtl/spi_stat_fill.sv
module spi_stat_fill (
    input  logic clk,
    input  logic rst_n,
    input  logic full_i,
    input  logic sw_clr_i,
    input  logic dma_ack_i,
    output logic fill_o
);
    logic fill_d, fill_q;

    always_comb begin
        fill_d = fill_q;
        if (!full_i)                     fill_d = 1'b1;
        else if (sw_clr_i || dma_ack_i)  fill_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fill_q <= 1'b1;
        else        fill_q <= fill_d;
    end

    assign fill_o = fill_q;
endmodule

// File: rtl/spi_stat_reg.sv
module spi_stat_reg
    import spi_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done_i,
    input  logic             eoq_done_i,
    input  logic             slv_start_i,
    input  logic             slave_mode_i,
    input  logic             tx_full_i,
    input  logic             tx_empty_i,
    input  logic             rx_full_i,
    input  logic             rx_empty_i,
    input  logic             start_req_i,
    input  logic             stop_req_i,
    input  logic             dma_ack_i,
    input  logic             wr_en_i,
    input  logic [SW_W-1:0]  wr_data_i,
    input  logic [FLD_W-1:0] tx_cnt_i,
    input  logic [FLD_W-1:0] tx_nxt_i,
    input  logic [FLD_W-1:0] rx_cnt_i,
    input  logic [FLD_W-1:0] rx_pop_i,
    output logic [SW_W-1:0]  status_o
);
    logic [N_STK-1:0] stk_set, stk_clr, stk_q;
    logic             run_q, fill_q;
    live_t            live_d, live_q;

    always_comb begin
        stk_set           = '0;
        stk_set[STK_TCF]  = frame_done_i;
        stk_set[STK_EOQ]  = eoq_done_i;
        stk_set[STK_UFL]  = slv_start_i && slave_mode_i && tx_empty_i;
        stk_set[STK_ROVF] = frame_done_i && rx_full_i;
    end

    for (genvar g = 0; g < N_STK; g++) begin : g_stk
        localparam int P = stk_pos(g);
        assign stk_clr[g] = wr_en_i && wr_data_i[P];
        spi_stat_w1c #(.RST_VAL(1'b0)) i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (stk_set[g]),
            .clr_i  (stk_clr[g]),
            .flag_o (stk_q[g])
        );
    end

    spi_stat_run i_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_req_i),
        .stop_i  (stop_req_i),
        .eoq_i   (eoq_done_i),
        .run_o   (run_q)
    );

    spi_stat_fill i_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_i    (tx_full_i),
        .sw_clr_i  (wr_en_i && wr_data_i[POS_FILL]),
        .dma_ack_i (dma_ack_i),
        .fill_o    (fill_q)
    );

    always_comb begin
        live_d        = live_q;
        live_d.drain  = !rx_empty_i;
        live_d.tx_cnt = tx_cnt_i;
        live_d.tx_nxt = tx_nxt_i;
        live_d.rx_cnt = rx_cnt_i;
        live_d.rx_pop = rx_pop_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    always_comb begin
        status_o = '0;
        for (int s = 0; s < N_STK; s++) status_o[stk_pos(s)] = stk_q[s];
        status_o[POS_RUN]                  = run_q;
        status_o[POS_FILL]                 = fill_q;
        status_o[POS_RDRN]                 = live_q.drain;
        status_o[TXC_LSB +: FLD_W]         = live_q.tx_cnt;
        status_o[TXP_LSB +: FLD_W]         = live_q.tx_nxt;
        status_o[RXC_LSB +: FLD_W]         = live_q.rx_cnt;
        status_o[RXP_LSB +: FLD_W]         = live_q.rx_pop;
    end
endmodule

// File: rtl/spi_stat_chk.sv
module spi_stat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_done_i,
    input logic        eoq_done_i,
    input logic        slv_start_i,
    input logic        slave_mode_i,
    input logic        tx_full_i,
    input logic        tx_empty_i,
    input logic        start_req_i,
    input logic        stop_req_i,
    input logic        wr_en_i,
    input logic [31:0] wr_data_i,
    input logic [31:0] status_o
);
    p_tcf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_i |=> status_o[31]);

    p_eoq_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eoq_done_i |=> (status_o[28] && !status_o[30]));

    p_ufl_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[27] && !(slv_start_i && slave_mode_i && tx_empty_i)) |=> !status_o[27]);

    p_fill_notfull_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_full_i |=> status_o[25]);

    p_wr0_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_data_i[31] && status_o[31]) |=> status_o[31]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoq_done_i && wr_en_i && wr_data_i[28]) |=> status_o[28]);

    p_start_runs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req_i && !stop_req_i && !eoq_done_i) |=> status_o[30]);

    p_stop_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req_i |=> !status_o[30]);

    p_rsv_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & 32'h25F5_0000) == 32'h0);
endmodule

bind spi_stat_reg spi_stat_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_done_i (frame_done_i),
    .eoq_done_i   (eoq_done_i),
    .slv_start_i  (slv_start_i),
    .slave_mode_i (slave_mode_i),
    .tx_full_i    (tx_full_i),
    .tx_empty_i   (tx_empty_i),
    .start_req_i  (start_req_i),
    .stop_req_i   (stop_req_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .status_o     (status_o)
);

// File: tb/test_spi_stat_reg.sv
`timescale 1ns/1ps
module test_spi_stat_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_done_i = 0, eoq_done_i = 0, slv_start_i = 0, slave_mode_i = 0;
    logic        tx_full_i = 0, tx_empty_i = 1, rx_full_i = 0, rx_empty_i = 1;
    logic        start_req_i = 0, stop_req_i = 0, dma_ack_i = 0, wr_en_i = 0;
    logic [31:0] wr_data_i = '0;
    logic [3:0]  tx_cnt_i = 0, tx_nxt_i = 0, rx_cnt_i = 0, rx_pop_i = 0;
    logic [31:0] status_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    spi_stat_reg i_spi_stat_reg (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one clock: inputs set at a negedge are sampled at the next posedge; result read at the next negedge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        frame_done_i = 0; eoq_done_i = 0; slv_start_i = 0; start_req_i = 0;
        stop_req_i = 0; dma_ack_i = 0; wr_en_i = 0; wr_data_i = '0;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en_i = 1; wr_data_i = d; cyc();
    endtask

    task automatic t_reset();
        chk("R1 reset word", status_o, 32'h0200_0000);
    endtask

    task automatic t_tcf();
        frame_done_i = 1; cyc();
        chk("R2 tcf set", 32'(status_o[31]), 1);
        cyc();
        chk("R2 tcf sticky", 32'(status_o[31]), 1);
        wr(32'h0);
        chk("R8 write 0 keeps tcf", 32'(status_o[31]), 1);
        wr(32'h8000_0000);
        chk("R8 write 1 clears tcf", 32'(status_o[31]), 0);
    endtask

    task automatic t_run();
        start_req_i = 1; stop_req_i = 1; cyc();
        chk("R10 stop beats start", 32'(status_o[30]), 0);
        start_req_i = 1; cyc();
        chk("R10 start runs", 32'(status_o[30]), 1);
        wr(32'hFFFF_FFFF);
        chk("R11 write keeps run", 32'(status_o[30]), 1);
        stop_req_i = 1; cyc();
        chk("R10 stop halts", 32'(status_o[30]), 0);
    endtask

    task automatic t_eoq();
        start_req_i = 1; cyc();
        eoq_done_i = 1; cyc();
        chk("R3 eoq flag", 32'(status_o[28]), 1);
        chk("R3 eoq stops run", 32'(status_o[30]), 0);
        wr(32'h1000_0000);
        chk("R8 eoq clear", 32'(status_o[28]), 0);
    endtask

    task automatic t_ufl();
        slave_mode_i = 0; tx_empty_i = 1; slv_start_i = 1; cyc();
        chk("R4 master mode ignored", 32'(status_o[27]), 0);
        slave_mode_i = 1; tx_empty_i = 0; slv_start_i = 1; cyc();
        chk("R4 fifo not empty", 32'(status_o[27]), 0);
        tx_empty_i = 1; slv_start_i = 1; cyc();
        chk("R4 underflow set", 32'(status_o[27]), 1);
        slave_mode_i = 0; cyc();
        chk("R4 underflow sticky", 32'(status_o[27]), 1);
        wr(32'h0800_0000);
    endtask

    task automatic t_fill();
        dma_ack_i = 1; cyc();
        chk("R5 ack ignored not full", 32'(status_o[25]), 1);
        wr(32'h0200_0000);
        chk("R5 write ignored not full", 32'(status_o[25]), 1);
        tx_full_i = 1; cyc();
        chk("R5 full holds", 32'(status_o[25]), 1);
        dma_ack_i = 1; cyc();
        chk("R5 dma clears", 32'(status_o[25]), 0);
        tx_full_i = 0; cyc();
        chk("R5 not full sets", 32'(status_o[25]), 1);
        tx_full_i = 1; wr(32'h0200_0000);
        chk("R5 write clears full", 32'(status_o[25]), 0);
        tx_full_i = 0; cyc();
    endtask

    task automatic t_rx();
        rx_full_i = 0; frame_done_i = 1; cyc();
        chk("R6 no overflow", 32'(status_o[19]), 0);
        rx_full_i = 1; frame_done_i = 1; cyc();
        rx_full_i = 0;
        chk("R6 overflow set", 32'(status_o[19]), 1);
        cyc();
        chk("R6 overflow sticky", 32'(status_o[19]), 1);
        wr(32'h8008_0000);
        chk("R8 overflow clear", 32'(status_o[19]), 0);
        rx_empty_i = 0; cyc();
        chk("R7 drain set", 32'(status_o[17]), 1);
        wr(32'h0002_0000);
        chk("R7 write ignored", 32'(status_o[17]), 1);
        rx_empty_i = 1; cyc();
        chk("R7 drain clear", 32'(status_o[17]), 0);
    endtask

    task automatic t_fields();
        tx_cnt_i = 4'h5; tx_nxt_i = 4'hA; rx_cnt_i = 4'h3; rx_pop_i = 4'hC; cyc();
        chk("R11 fields", 32'(status_o[15:0]), 32'h5A3C);
        wr(32'h0000_FFFF);
        chk("R11 fields write ignored", 32'(status_o[15:0]), 32'h5A3C);
    endtask

    task automatic t_collide();
        frame_done_i = 1; wr_en_i = 1; wr_data_i = 32'h8000_0000; cyc();
        chk("R9 tcf set beats clear", 32'(status_o[31]), 1);
        eoq_done_i = 1; wr_en_i = 1; wr_data_i = 32'h1000_0000; cyc();
        chk("R9 eoq set beats clear", 32'(status_o[28]), 1);
    endtask

    task automatic t_reserved();
        wr(32'hFFFF_FFFF);
        chk("R12 reserved zero", status_o & 32'h25F5_0000, 0);
        rx_empty_i = 0; start_req_i = 1; frame_done_i = 1; cyc();
        chk("R12 reserved zero busy", status_o & 32'h25F5_0000, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_tcf();
        t_run();
        t_eoq();
        t_ufl();
        t_fill();
        t_rx();
        t_fields();
        t_collide();
        t_reserved();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule